// File: doc/BRIEF.md
# Frame-Paced Clock and Countdown Timer Bank

This block keeps the time that software measures in video frames. Each time the one-cycle `frame_tick` pulse arrives, it adds one to a 24-bit frame clock and advances a set of countdown counters. The work for one tick is split into two stages. Stage one always runs: it updates the frame clock and countdown timer 1. Stage two covers countdown timers 2 to 5 and an 8-bit key debounce counter. It runs only when `critical` is low in the tick cycle, so a frame that lands inside a critical section skips it.

Timers 1 and 2 report expiry as single-cycle event pulses, which a callback dispatcher outside the block consumes. Timers 3 to 5 report expiry through sticky flags that software polls and clears. Every counter is loaded, and every value is read, through a small register port. Reads have a one-cycle latency. The 24-bit clock is loaded and read one byte at a time, but it always changes and is captured as a single value.

Top module: `frame_timer_bank`

## Requirements
- R1: After reset, all countdowns, the debounce counter, the frame clock, the flags, both event outputs and `rd_data` are zero.
- R2: Each `frame_tick` adds one to the frame clock, whatever the level of `critical`. The clock wraps from 0xFFFFFF to 0.
- R3: Writes to address 7 (bits 23:16) and address 8 (bits 15:8) only stage bytes. A write to address 9 commits the staged bytes together with its own data[7:0] (bits 7:0) as one 24-bit value, and this commit overrides a tick in the same cycle.
- R4: A read of address 7 returns clock bits 23:16. The same read captures bits 15:0. Reads of addresses 8 and 9 return the captured bits 15:8 and 7:0, and later ticks do not change them.
- R5: Timer 1 (address 0) counts down on every tick, whether or not `critical` is high. When it steps from 1 to 0, `t1_expired` is high for exactly the one cycle after that edge.
- R6: Timers 2 to 5 (addresses 1 to 4) count down on a tick only while `critical` is low. They hold their value otherwise.
- R7: When timer 2 steps from 1 to 0 on a stage-two tick, `t2_expired` is high for exactly one cycle.
- R8: When timers 3, 4 and 5 step from 1 to 0, they set `flags_out` bits 0, 1 and 2. Address 6 reads the flags back in rd_data[2:0]. A flag stays set until it is cleared.
- R9: A timer that holds zero stays at zero on ticks and raises no event or flag.
- R10: A write to a timer address loads data[15:0] and overrides a tick in the same cycle. A nonzero load clears that timer's flag.
- R11: A write to address 6 clears each flag whose data bit (bit 0 to 2) is 0 and leaves each flag whose bit is 1 unchanged. An expiry in the same cycle wins over the clear.
- R12: The debounce counter (address 5, data[7:0]) counts down on a stage-two tick only while it is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per frame |
| critical | input | 1 | High during a critical section; suppresses stage two |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Read data, valid the cycle after `rd_en`; holds otherwise |
| t1_expired | output | 1 | Timer 1 expiry pulse |
| t2_expired | output | 1 | Timer 2 expiry pulse |
| flags_out | output | 3 | Sticky expiry flags of timers 3, 4 and 5 |

## Verification
The bench builds the block with its default widths: 16-bit timers, an 8-bit debounce counter and a 24-bit clock. It reaches the clock wrap by committing 0xFFFFFF through the byte-staged load, so it does not need sixteen million ticks. Random loads are kept to small values, which makes expiries, zero holds and collisions between a load and a tick or between an expiry and a flag clear occur often within a few thousand cycles.

// File: rtl/ftb_pkg.sv
package ftb_pkg;
  localparam int NUM_TMR   = 5;
  localparam int NUM_FLAGS = 3;
  localparam int FIRST_FLAG_TMR = NUM_TMR - NUM_FLAGS;

  typedef enum logic [3:0] {
    RA_DBN    = 4'd5,
    RA_FLAGS  = 4'd6,
    RA_CLK_HI = 4'd7,
    RA_CLK_MD = 4'd8,
    RA_CLK_LO = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/ftb_countdown.sv
module ftb_countdown #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dec_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         hit
);
  assign hit = dec_en && !load && (count == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (load)                  count <= load_val;
    else if (dec_en && count != '0) count <= count - W'(1);
  end

  // R9
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load) |=> count == '0);
  // R5
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !load && count != '0) |=> count == $past(count) - W'(1));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_en && !load) |=> $stable(count));
  // R10
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
endmodule

// File: rtl/ftb_rtc.sv
module ftb_rtc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        stage_hi,
  input  logic        stage_md,
  input  logic        commit,
  input  logic [7:0]  byte_in,
  output logic [23:0] value
);
  logic [7:0] hi_q, md_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      md_q <= '0;
    end else begin
      if (stage_hi) hi_q <= byte_in;
      if (stage_md) md_q <= byte_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (commit) value <= {hi_q, md_q, byte_in};
    else if (tick)   value <= value + 24'd1;
  end

  // R2
  rtc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !commit) |=> value == $past(value) + 24'd1);
  // R3
  rtc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !commit) |=> $stable(value));
endmodule

// File: rtl/frame_timer_bank.sv
module frame_timer_bank
  import ftb_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int DBN_W  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              critical,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              t1_expired,
  output logic              t2_expired,
  output logic [NUM_FLAGS-1:0] flags_out
);
  localparam int CLK_W = 24;

  logic             stage2;
  logic [TMR_W-1:0] cnt [NUM_TMR];
  logic [NUM_TMR-1:0] ld, hit;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [DBN_W-1:0] dbn_q;
  logic [CLK_W-1:0] rtc;
  logic [15:0]      snap_q;
  logic             wr_flags, ld_dbn;

  assign stage2   = frame_tick && !critical;
  assign wr_flags = wr_en && (wr_addr == RA_FLAGS);
  assign ld_dbn   = wr_en && (wr_addr == RA_DBN);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic dec_en;
    assign ld[i]  = wr_en && (wr_addr == ADDR_W'(i));
    assign dec_en = (i == 0) ? frame_tick : stage2;
    ftb_countdown #(.W(TMR_W)) u_cd (
      .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .load(ld[i]),
      .load_val(wr_data[TMR_W-1:0]), .count(cnt[i]), .hit(hit[i])
    );
  end

  for (genvar j = 0; j < NUM_FLAGS; j++) begin : g_flag
    localparam int TI = FIRST_FLAG_TMR + j;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  flag_q[j] <= 1'b0;
      else if (hit[TI])                            flag_q[j] <= 1'b1;
      else if (ld[TI] && wr_data[TMR_W-1:0] != '0) flag_q[j] <= 1'b0;
      else if (wr_flags && !wr_data[j])            flag_q[j] <= 1'b0;
    end
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[j] && !ld[TI] && !wr_flags) |=> flag_q[j]);
    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[TI] |=> flag_q[j]);
  end
  assign flags_out = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1_expired <= 1'b0;
      t2_expired <= 1'b0;
    end else begin
      t1_expired <= hit[0];
      t2_expired <= hit[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      dbn_q <= '0;
    else if (ld_dbn)                 dbn_q <= wr_data[DBN_W-1:0];
    else if (stage2 && dbn_q != '0)  dbn_q <= dbn_q - DBN_W'(1);
  end

  ftb_rtc u_rtc (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick),
    .stage_hi(wr_en && wr_addr == RA_CLK_HI),
    .stage_md(wr_en && wr_addr == RA_CLK_MD),
    .commit(wr_en && wr_addr == RA_CLK_LO),
    .byte_in(wr_data[7:0]), .value(rtc)
  );

  logic [DATA_W-1:0] tmr_sel;
  always_comb begin
    tmr_sel = '0;
    for (int k = 0; k < NUM_TMR; k++)
      if (rd_addr == ADDR_W'(k)) tmr_sel = DATA_W'(cnt[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      snap_q  <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        RA_DBN:    rd_data <= DATA_W'(dbn_q);
        RA_FLAGS:  rd_data <= DATA_W'(flag_q);
        RA_CLK_HI: begin
          rd_data <= DATA_W'(rtc[23:16]);
          snap_q  <= rtc[15:0];
        end
        RA_CLK_MD: rd_data <= DATA_W'(snap_q[15:8]);
        RA_CLK_LO: rd_data <= DATA_W'(snap_q[7:0]);
        default:   rd_data <= tmr_sel;
      endcase
    end
  end

  // R5
  t1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t1_expired |=> !t1_expired);
  // R7
  t2_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t2_expired |=> !t2_expired);
  // R12
  dbn_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbn_q == '0 && !ld_dbn) |=> dbn_q == '0);
  // R6
  dbn_crit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage2 && !ld_dbn) |=> $stable(dbn_q));
endmodule

// File: tb/frame_timer_bank_tb.sv
module frame_timer_bank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 0, critical = 0, wr_en = 0, rd_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic t1_expired, t2_expired;
  logic [2:0] flags_out;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  frame_timer_bank u_dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .critical(critical),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .t1_expired(t1_expired), .t2_expired(t2_expired), .flags_out(flags_out)
  );

  logic [15:0] m_t [5];
  logic [7:0]  m_dbn, m_hi, m_md;
  logic [23:0] m_rtc;
  logic [2:0]  m_fl;
  logic [15:0] m_snap, m_rd;
  logic        m_e1, m_e2;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic string rd_tag(input logic [3:0] a);
    if (a <= 4)      return "R6";
    else if (a == 5) return "R12";
    else if (a == 6) return "R11";
    else             return "R4";
  endfunction

  task automatic cyc(input bit tk, input bit cr, input bit we, input logic [3:0] wa,
                     input logic [15:0] wd, input bit re, input logic [3:0] ra);
    logic [4:0] h;
    @(negedge clk);
    frame_tick = tk; critical = cr; wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra;
    if (re) begin
      case (ra)
        4'd0, 4'd1, 4'd2, 4'd3, 4'd4: m_rd = m_t[ra];
        4'd5: m_rd = {8'h0, m_dbn};
        4'd6: m_rd = {13'h0, m_fl};
        4'd7: begin m_rd = {8'h0, m_rtc[23:16]}; m_snap = m_rtc[15:0]; end
        4'd8: m_rd = {8'h0, m_snap[15:8]};
        4'd9: m_rd = {8'h0, m_snap[7:0]};
        default: m_rd = 16'h0;
      endcase
    end
    h = '0;
    for (int i = 0; i < 5; i++) begin
      if (we && wa == 4'(i)) m_t[i] = wd;
      else if (tk && (i == 0 || !cr) && m_t[i] != 0) begin
        m_t[i] = m_t[i] - 16'd1;
        h[i] = (m_t[i] == 0);
      end
    end
    for (int j = 0; j < 3; j++) begin
      if (h[j+2]) m_fl[j] = 1'b1;
      else if (we && wa == 4'(j+2) && wd != 0) m_fl[j] = 1'b0;
      else if (we && wa == 4'd6 && !wd[j]) m_fl[j] = 1'b0;
    end
    if (we && wa == 4'd5) m_dbn = wd[7:0];
    else if (tk && !cr && m_dbn != 0) m_dbn = m_dbn - 8'd1;
    if (we && wa == 4'd9) m_rtc = {m_hi, m_md, wd[7:0]};
    else if (tk) m_rtc = m_rtc + 24'd1;
    if (we && wa == 4'd7) m_hi = wd[7:0];
    if (we && wa == 4'd8) m_md = wd[7:0];
    m_e1 = h[0]; m_e2 = h[1];
    @(posedge clk);
    #1;
    chk("R5", t1_expired, m_e1);
    chk("R7", t2_expired, m_e2);
    chk("R8", flags_out, m_fl);
    if (re) chk(rd_tag(ra), rd_data, m_rd);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d); cyc(0, 0, 1, a, d, 0, 0); endtask
  task automatic rd(input logic [3:0] a); cyc(0, 0, 0, 0, 0, 1, a); endtask
  task automatic tick(input bit cr); cyc(1, cr, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 5; i++) m_t[i] = 0;
    m_dbn = 0; m_hi = 0; m_md = 0; m_rtc = 0; m_fl = 0; m_snap = 0; m_rd = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", {t1_expired, t2_expired, flags_out}, 0);
    chk("R1", rd_data, 0);
    rst_n = 1'b1;
    rd(0); chk("R1", rd_data, 0);
    rd(7); chk("R1", rd_data, 0);

    // R5 timer 1 runs even in critical
    wr(0, 2); tick(1); chk("R5", t1_expired, 0);
    tick(1); chk("R5", t1_expired, 1);
    rd(0); chk("R5", t1_expired, 0);
    // R9 zero holds
    tick(0); chk("R9", t1_expired, 0);
    rd(0); chk("R9", rd_data, 0);

    // R6 critical skip
    wr(1, 5); tick(1); rd(1); chk("R6", rd_data, 5);
    tick(0); rd(1); chk("R6", rd_data, 4);
    // R7
    wr(1, 1); tick(0); chk("R7", t2_expired, 1);
    rd(1); chk("R7", t2_expired, 0);

    // R3 / R2 clock load and wrap
    wr(7, 16'hFF); wr(8, 16'hFF);
    rd(7); chk("R3", rd_data, m_rtc[23:16]);
    wr(9, 16'hFF); rd(7); chk("R3", rd_data, 16'hFF);
    rd(9); chk("R3", rd_data, 16'hFF);
    tick(1); rd(7); chk("R2", rd_data, 0);
    rd(9); chk("R2", rd_data, 0);
    // R4 snapshot unchanged by later ticks
    wr(9, 16'h34); rd(7); tick(0); tick(0);
    rd(9); chk("R4", rd_data, 16'h34);
    rd(8); chk("R4", rd_data, 16'hFF);

    // R8 / R10 flags
    wr(2, 1); tick(0); chk("R8", flags_out, 3'b001);
    tick(0); chk("R8", flags_out, 3'b001);
    wr(2, 3); chk("R10", flags_out, 3'b000);
    cyc(1, 0, 1, 0, 7, 0, 0); rd(0); chk("R10", rd_data, 7);
    // R11 flag clear by write of 0
    wr(3, 1); wr(4, 1); tick(0); chk("R11", flags_out, 3'b110);
    wr(6, 16'h5); chk("R11", flags_out, 3'b100);
    wr(6, 16'h7); chk("R11", flags_out, 3'b100);
    wr(6, 16'h0); rd(6); chk("R11", rd_data, 0);

    // R12 debounce floor
    wr(5, 1); tick(1); rd(5); chk("R12", rd_data, 1);
    tick(0); rd(5); chk("R12", rd_data, 0);
    tick(0); rd(5); chk("R12", rd_data, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit tk, cr, we, re;
      logic [3:0] wa, ra;
      logic [15:0] wd;
      tk = ($urandom % 3) != 0;
      cr = ($urandom % 4) == 0;
      we = ($urandom % 4) == 0;
      re = ($urandom % 3) == 0;
      wa = 4'($urandom % 10);
      ra = 4'($urandom % 10);
      wd = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom % 5);
      cyc(tk, cr, we, wa, wd, re, ra);
    end
    for (int a = 0; a < 10; a++) rd(4'(a));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule